// File: doc/BRIEF.md
# Strided Block Address Generator

This block produces the byte addresses for one side of a DMA transfer, either the read side or the write side. A one-cycle start pulse loads the start address, a 32-bit configuration word and a byte count. The block then offers one address per beat on a valid/ready handshake. Each accepted beat moves the address by the beat size. The direction depends on the configured movement: upward, downward, held in place, or wrapping inside an aligned group of beats. When block grouping is enabled, a stride is applied after the last beat of each block, so one-dimensional gather and scatter patterns can be walked without software help. Data movement and bus protocol are handled elsewhere.

The controller is a four-state machine. `ST_IDLE` is the reset state. A start in `ST_IDLE`, `ST_FINISH` or `ST_FAULT` takes one of three transitions: to `ST_RUN` when the count is a non-zero multiple of the beat size, to `ST_FINISH` when the count is zero, or to `ST_FAULT` when the count leaves a partial beat. `ST_RUN` stays in place until the beat that uses up the count is accepted, then moves to `ST_FINISH`. `ST_FINISH` and `ST_FAULT` hold until the next start.

Top module: `strided_agen`

## Requirements
- R1: While reset is asserted and after its release, beat_valid_o, done_o and err_o are low until a start is accepted.
- R2: A start accepted at a clock edge with a valid non-zero count makes beat_valid_o high after that edge, and the first beat_addr_o equals start_addr_i.
- R3: Configuration bits 31:30 give the beat size: code 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. The number of beats is the byte count divided by the beat size.
- R4: Movement code 0 in configuration bits 29:28 raises the address by the beat size after each accepted beat.
- R5: Movement code 1 lowers the address by the beat size after each accepted beat.
- R6: Movement code 2 holds the address for every beat.
- R7: Movement code 3 raises the address by the beat size inside an aligned group of 4 beats (4 × beat size bytes). Past the group's end it wraps to the group's base.
- R8: Configuration bits 27:14 give the block length in beats, where 0 disables blocking. Bits 13:0 give the stride in bytes. After the last beat of each block the stride is added on top of the normal move, or subtracted when movement code 1 is selected.
- R9: While beat_valid_o is high and beat_ready_i is low, beat_valid_o stays high and beat_addr_o does not change.
- R10: done_o rises in the cycle after the beat that uses up the byte count is accepted. beat_valid_o falls at the same time, and done_o stays high until the next start.
- R11: A start whose count is not a multiple of the beat size sets err_o and produces no beats. A start with a zero count sets done_o and produces no beats.
- R12: A start pulse while beats are still pending is ignored, and the running transfer continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, loads the three inputs below |
| start_addr_i | input | ADDR_W | First byte address |
| xfer_cfg_i | input | 32 | Size code, movement code, block length, stride |
| byte_count_i | input | CNT_W | Total bytes to walk |
| beat_ready_i | input | 1 | Consumer accepts the current beat |
| beat_valid_o | output | 1 | An address is offered |
| beat_addr_o | output | ADDR_W | Address of the current beat |
| done_o | output | 1 | Transfer complete |
| err_o | output | 1 | Count left a partial beat |

## Verification
The bench uses the default parameters: 32-bit addresses, a 22-bit count and 4-beat wrap groups. With these settings every size code and every movement code can be reached with counts of a few dozen bytes. Short blocks (2 or 3 beats) with odd strides place several block boundaries inside one transfer, in both directions. A start address placed in the middle of a group brings the burst wrap within a single transfer. Ready is driven always high, in a periodic gap pattern and pseudo-randomly, so stalls land on block ends and on final beats.

// File: rtl/agen_pkg.sv
package agen_pkg;
    localparam int FLD_W = 14;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FINISH,
        ST_FAULT
    } agen_state_e;

    typedef enum logic [1:0] {
        MV_INC    = 2'd0,
        MV_DEC    = 2'd1,
        MV_STATIC = 2'd2,
        MV_BURST  = 2'd3
    } agen_mode_e;

    typedef struct packed {
        logic [1:0]       size;
        agen_mode_e       mode;
        logic [FLD_W-1:0] blk;
        logic [FLD_W-1:0] stride;
    } agen_cfg_t;
endpackage

// File: rtl/agen_walk.sv
module agen_walk
    import agen_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BURST_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  agen_cfg_t         cfg_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [1:0]        size_o
);
    agen_cfg_t         cfg_q;
    logic [ADDR_W-1:0] cur_q;
    logic [FLD_W-1:0]  blk_cnt_q;

    logic [ADDR_W-1:0] beat_bytes;
    logic [ADDR_W-1:0] grp_mask;
    logic [ADDR_W-1:0] stride_ext;
    logic [ADDR_W-1:0] moved;
    logic [ADDR_W-1:0] next_addr;
    logic              blk_end;

    assign beat_bytes = ADDR_W'(1) << cfg_q.size;
    assign grp_mask   = (beat_bytes << BURST_LOG2) - ADDR_W'(1);
    assign stride_ext = ADDR_W'(cfg_q.stride);
    assign blk_end    = (cfg_q.blk != '0) && (blk_cnt_q == cfg_q.blk - FLD_W'(1));

    always_comb begin
        unique case (cfg_q.mode)
            MV_INC:    moved = cur_q + beat_bytes;
            MV_DEC:    moved = cur_q - beat_bytes;
            MV_STATIC: moved = cur_q;
            MV_BURST:  moved = (cur_q & ~grp_mask) | ((cur_q + beat_bytes) & grp_mask);
            default:   moved = cur_q;
        endcase
        if (!blk_end)
            next_addr = moved;
        else if (cfg_q.mode == MV_DEC)
            next_addr = moved - stride_ext;
        else
            next_addr = moved + stride_ext;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            cur_q     <= '0;
            blk_cnt_q <= '0;
        end else if (load_i) begin
            cfg_q     <= cfg_i;
            cur_q     <= start_addr_i;
            blk_cnt_q <= '0;
        end else if (step_i) begin
            cur_q <= next_addr;
            if (blk_end || cfg_q.blk == '0)
                blk_cnt_q <= '0;
            else
                blk_cnt_q <= blk_cnt_q + FLD_W'(1);
        end
    end

    assign addr_o = cur_q;
    assign size_o = cfg_q.size;

    // R4: plain step upward inside a block
    a_r4_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && cfg_q.mode == MV_INC && !blk_end)
        |=> cur_q == $past(cur_q) + $past(beat_bytes));

    // R6: static mode holds the address inside a block
    a_r6_static_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && cfg_q.mode == MV_STATIC && !blk_end) |=> $stable(cur_q));

    // R7: burst stays inside its aligned group
    a_r7_burst_group: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && cfg_q.mode == MV_BURST && !blk_end)
        |=> (cur_q & ~grp_mask) == ($past(cur_q) & ~$past(grp_mask)));
endmodule

// File: rtl/agen_ctrl.sv
module agen_ctrl
    import agen_pkg::*;
#(
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [1:0]       size_new_i,
    input  logic [1:0]       size_run_i,
    input  logic             fire_i,
    output logic             load_o,
    output logic             valid_o,
    output logic             done_o,
    output logic             err_o
);
    agen_state_e      state_q, state_d;
    logic [CNT_W-1:0] rem_q;
    logic [CNT_W-1:0] new_bytes;
    logic [CNT_W-1:0] run_bytes;
    logic             partial;
    logic             last_beat;

    assign new_bytes = CNT_W'(1) << size_new_i;
    assign run_bytes = CNT_W'(1) << size_run_i;
    assign partial   = (count_i & (new_bytes - CNT_W'(1))) != '0;
    assign load_o    = start_i && (state_q != ST_RUN);
    assign last_beat = fire_i && (rem_q == run_bytes);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: if (last_beat) state_d = ST_FINISH;
            ST_IDLE, ST_FINISH, ST_FAULT: begin
                if (load_o) begin
                    if (partial)              state_d = ST_FAULT;
                    else if (count_i == '0)   state_d = ST_FINISH;
                    else                      state_d = ST_RUN;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load_o)
                rem_q <= count_i;
            else if (fire_i)
                rem_q <= rem_q - run_bytes;
        end
    end

    always_comb begin
        valid_o = (state_q == ST_RUN);
        done_o  = (state_q == ST_FINISH);
        err_o   = (state_q == ST_FAULT);
    end

    // R10: done follows the exhausting beat
    a_r10_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |=> done_o && !valid_o);

    // R11: partial count goes to fault with no beats
    a_r11_partial_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (load_o && partial) |=> err_o && !valid_o);

    // R12: running transfer keeps going until its last beat
    a_r12_run_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_beat) |=> valid_o);
endmodule

// File: rtl/strided_agen.sv
module strided_agen
    import agen_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 22,
    parameter int BURST_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [31:0]       xfer_cfg_i,
    input  logic [CNT_W-1:0]  byte_count_i,
    input  logic              beat_ready_i,
    output logic              beat_valid_o,
    output logic [ADDR_W-1:0] beat_addr_o,
    output logic              done_o,
    output logic              err_o
);
    agen_cfg_t  cfg_in;
    logic       load;
    logic       fire;
    logic [1:0] size_run;

    assign cfg_in = agen_cfg_t'(xfer_cfg_i);
    assign fire   = beat_valid_o && beat_ready_i;

    agen_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .count_i    (byte_count_i),
        .size_new_i (cfg_in.size),
        .size_run_i (size_run),
        .fire_i     (fire),
        .load_o     (load),
        .valid_o    (beat_valid_o),
        .done_o     (done_o),
        .err_o      (err_o)
    );

    agen_walk #(.ADDR_W(ADDR_W), .BURST_LOG2(BURST_LOG2)) u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load),
        .start_addr_i (start_addr_i),
        .cfg_i        (cfg_in),
        .step_i       (fire),
        .addr_o       (beat_addr_o),
        .size_o       (size_run)
    );

    // R9: a stalled beat is held
    a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && !beat_ready_i) |=> beat_valid_o && $stable(beat_addr_o));

    // R10 / R11: outputs are mutually exclusive
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({beat_valid_o, done_o, err_o}));
endmodule

// File: tb/tb_strided_agen.sv
module tb_strided_agen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] start_addr_i = '0;
    logic [31:0] xfer_cfg_i = '0;
    logic [21:0] byte_count_i = '0;
    logic        beat_ready_i = 1'b0;
    logic        beat_valid_o;
    logic [31:0] beat_addr_o;
    logic        done_o;
    logic        err_o;

    always #2.5 clk = ~clk;

    strided_agen dut (.*);

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    string cur_req = "R1";
    logic [31:0] capq[$];

    // reference model
    int          m_state = 0;  // 0 idle, 1 run, 2 finished, 3 fault
    logic [31:0] m_addr = '0;
    int unsigned m_rem = 0, m_bb = 1, m_mode = 0, m_blk = 0, m_stride = 0, m_bcnt = 0;

    task automatic chk(string req, bit ok, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(int sz, int md, int blk, int str);
        return {sz[1:0], md[1:0], blk[13:0], str[13:0]};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_addr = '0; m_rem = 0;
        end else if (m_state == 1) begin
            if (beat_ready_i) begin
                capq.push_back(beat_addr_o);
                if (m_rem == m_bb) m_state = 2;
                m_rem = m_rem - m_bb;
                case (m_mode)
                    0: m_addr = m_addr + m_bb;
                    1: m_addr = m_addr - m_bb;
                    2: ;
                    default: begin
                        int unsigned grp, off;
                        grp = m_bb * 4;
                        off = m_addr % grp;
                        m_addr = m_addr - off + ((off + m_bb) % grp);
                    end
                endcase
                if (m_blk != 0) begin
                    m_bcnt++;
                    if (m_bcnt == m_blk) begin
                        m_bcnt = 0;
                        if (m_mode == 1) m_addr = m_addr - m_stride;
                        else m_addr = m_addr + m_stride;
                    end
                end
            end
        end else if (start_i) begin
            m_bb     = 1 << xfer_cfg_i[31:30];
            m_mode   = xfer_cfg_i[29:28];
            m_blk    = xfer_cfg_i[27:14];
            m_stride = xfer_cfg_i[13:0];
            m_addr   = start_addr_i;
            m_rem    = byte_count_i;
            m_bcnt   = 0;
            if (m_rem % m_bb != 0) m_state = 3;
            else if (m_rem == 0)   m_state = 2;
            else                   m_state = 1;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(cur_req, beat_valid_o == (m_state == 1), "beat_valid_o", beat_valid_o, m_state == 1);
            chk(cur_req, done_o == (m_state == 2), "done_o", done_o, m_state == 2);
            chk(cur_req, err_o == (m_state == 3), "err_o", err_o, m_state == 3);
            if (m_state == 1)
                chk(cur_req, beat_addr_o == m_addr, "beat_addr_o", beat_addr_o, m_addr);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic bit rdy(int pat);
        case (pat)
            0: return 1'b1;
            1: return (cyc % 3) != 0;
            default: return ($urandom % 4) != 0;
        endcase
    endfunction

    task automatic xfer(string req, logic [31:0] a, logic [31:0] c, int cnt, int pat);
        cur_req = req;
        capq.delete();
        @(negedge clk);
        start_i = 1'b1; start_addr_i = a; xfer_cfg_i = c; byte_count_i = 22'(cnt);
        beat_ready_i = rdy(pat);
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            if (done_o || err_o) break;
            beat_ready_i = rdy(pat);
            @(negedge clk);
        end
        beat_ready_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic cmp_list(string req, logic [31:0] exp[$]);
        chk(req, capq.size() == exp.size(), "beat count", capq.size(), exp.size());
        for (int i = 0; i < exp.size() && i < capq.size(); i++)
            chk(req, capq[i] == exp[i], "address", capq[i], exp[i]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", !beat_valid_o && !done_o && !err_o, "outputs in reset",
            {beat_valid_o, done_o, err_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", !beat_valid_o && !done_o && !err_o, "outputs after reset",
            {beat_valid_o, done_o, err_o}, 0);

        // R2 / R4: increment, 4-byte beats
        xfer("R4", 32'h400, mk(2, 0, 0, 0), 32, 0);
        chk("R2", capq.size() > 0 && capq[0] == 32'h400, "first address", capq.size() > 0 ? capq[0] : 0, 32'h400);
        cmp_list("R4", '{32'h400, 32'h404, 32'h408, 32'h40C, 32'h410, 32'h414, 32'h418, 32'h41C});

        // R3: each size code
        for (int s = 0; s < 4; s++) begin
            xfer("R3", 32'h800, mk(s, 0, 0, 0), 16, 1);
            chk("R3", capq.size() == (16 >> s), "beats for size code", capq.size(), 16 >> s);
        end

        // R5: decrement, 2-byte beats
        xfer("R5", 32'h200, mk(1, 1, 0, 0), 8, 2);
        cmp_list("R5", '{32'h200, 32'h1FE, 32'h1FC, 32'h1FA});

        // R6: static, 8-byte beats
        xfer("R6", 32'h3000, mk(3, 2, 0, 0), 24, 1);
        cmp_list("R6", '{32'h3000, 32'h3000, 32'h3000});

        // R7: burst wrap from mid-group
        xfer("R7", 32'h108, mk(2, 3, 0, 0), 24, 2);
        cmp_list("R7", '{32'h108, 32'h10C, 32'h100, 32'h104, 32'h108, 32'h10C});

        // R8: stride upward, 1-byte beats, blocks of 2, stride 5
        xfer("R8", 32'h20, mk(0, 0, 2, 5), 5, 0);
        cmp_list("R8", '{32'h20, 32'h21, 32'h27, 32'h28, 32'h2E});
        // R8: stride downward, blocks of 3, stride 4
        xfer("R8", 32'h100, mk(1, 1, 3, 4), 8, 1);
        cmp_list("R8", '{32'h100, 32'hFE, 32'hFC, 32'hF6});
        // R8: stride with burst and static
        xfer("R8", 32'h500, mk(2, 3, 3, 64), 40, 2);
        xfer("R8", 32'h700, mk(0, 2, 2, 3), 6, 2);

        // R9: explicit stall hold
        cur_req = "R9";
        @(negedge clk);
        start_i = 1'b1; start_addr_i = 32'h40; xfer_cfg_i = mk(2, 0, 0, 0); byte_count_i = 22'd12;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9", beat_valid_o && beat_addr_o == 32'h40, "stalled beat", beat_addr_o, 32'h40);
        beat_ready_i = 1'b1;
        @(negedge clk);
        beat_ready_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9", beat_valid_o && beat_addr_o == 32'h44, "stalled second beat", beat_addr_o, 32'h44);
        beat_ready_i = 1'b1;
        @(negedge clk);
        // R10: last beat accepted at the next edge
        @(negedge clk);
        beat_ready_i = 1'b0;
        chk("R10", done_o && !beat_valid_o, "done after last beat", {done_o, beat_valid_o}, 2'b10);
        repeat (3) @(negedge clk);
        chk("R10", done_o, "done held", done_o, 1);

        // R11: partial count and zero count
        xfer("R11", 32'h10, mk(2, 0, 0, 0), 6, 0);
        chk("R11", err_o && capq.size() == 0, "partial count fault", {err_o, capq.size() == 0}, 2'b11);
        xfer("R11", 32'h10, mk(3, 0, 0, 0), 0, 0);
        chk("R11", done_o && capq.size() == 0, "zero count done", {done_o, capq.size() == 0}, 2'b11);

        // R12: start mid-run ignored
        cur_req = "R12";
        capq.delete();
        @(negedge clk);
        start_i = 1'b1; start_addr_i = 32'h900; xfer_cfg_i = mk(0, 0, 0, 0); byte_count_i = 22'd4;
        @(negedge clk);
        start_i = 1'b1; start_addr_i = 32'hF00; xfer_cfg_i = mk(3, 1, 0, 0); byte_count_i = 22'd8;
        beat_ready_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (6) @(negedge clk);
        beat_ready_i = 1'b0;
        cmp_list("R12", '{32'h900, 32'h901, 32'h902, 32'h903});

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule